// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus side of a byte-wide serial memory that answers on a two-wire bus with an open-drain data line. It samples the clock and data lines with the system clock and detects START and STOP. It decodes the command byte against three strap pins. A write command is followed by two address bytes that load the address counter. Any data bytes after those are collected in a one-page buffer. A STOP then hands the buffer to a programming sequencer, which copies the collected bytes into a synchronous RAM and stays busy for a fixed number of cycles. While the sequencer is busy, the block ignores its own address.

A read command returns bytes from the address counter. A read can start at the current address, or at a new address when a write command with address bytes is followed by a repeated START and a read command. The read goes on for as long as the master acknowledges each byte. The address width is set by the parameter `ADDR_W`: 13 gives an 8192-byte array, and the default of 11 keeps the model small. Pages are 2^`PAGE_W` bytes, 32 by default.

The control FSM has these states: `ST_IDLE`, `ST_CMD`, `ST_CMD_ACK`, `ST_AHI`, `ST_AHI_ACK`, `ST_ALO`, `ST_ALO_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` and `ST_RACK`. Its transitions are:
- START leads from any state to `ST_CMD`.
- STOP leads from any state to `ST_IDLE`.
- `ST_CMD` goes to `ST_CMD_ACK` on a match, and back to `ST_IDLE` when the command does not match or the sequencer is busy.
- `ST_CMD_ACK` goes to `ST_RDATA` for a read command and to `ST_AHI` for a write command.
- The write path runs `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDATA`. It then cycles `ST_WDATA` ↔ `ST_WDATA_ACK`.
- The read path goes `ST_RDATA` → `ST_RACK`. From `ST_RACK` it returns to `ST_RDATA` when the master acknowledges, and goes to `ST_IDLE` when it does not.

The sequencer has three states: `SQ_IDLE` → `SQ_COPY` (one buffer slot per cycle) → `SQ_WAIT` (`PROG_CYCLES` cycles) → `SQ_IDLE`.

Top module: `eep_i2c_slave`

## Requirements
- R1: The block acknowledges a command byte only when bits 7..4 equal 1010 and bits 3..1 equal `chip_sel[2:0]`. Bit 0 selects the operation: 0 is write, 1 is read. On any other command byte it gives no acknowledge and keeps SDA released until the next START.
- R2: For every byte it accepts, the block holds `sda_pull` high through the whole high phase of the ninth SCL clock of that byte. `sda_pull` never changes while SCL is high.
- R3: After a write command, the low `ADDR_W`-8 bits of the first address byte form address bits `ADDR_W`-1..8, and its upper bits are ignored. The second address byte forms bits 7..0.
- R4: During a write, only the low `PAGE_W` address bits advance after each data byte, so bytes written past the page end wrap to the start of the same page.
- R5: During a read, the whole address counter advances after each byte sent, and it wraps from the top address to 0.
- R6: A repeated START after the address bytes of a write command cancels the write: nothing is programmed. A read command that follows returns data from the loaded address, or from the advanced address if data bytes were sent.
- R7: A read with no address bytes starts at the current counter. The read goes on while the master acknowledges. After a missing acknowledge, SDA stays released.
- R8: A STOP after at least one data byte starts programming. Until programming ends, the block acknowledges neither read nor write commands. After it ends, commands are acknowledged again.
- R9: While `wr_prot` is high at the STOP, no programming starts and the array is left unchanged.
- R10: A STOP that follows the address bytes with no data byte starts no programming.
- R11: After reset, `sda_pull` is low and commands are acknowledged at once.
- R12: A START in the middle of a byte abandons that byte, and the byte that follows is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 drives the data line low; 0 releases it |
| chip_sel | input | 3 | Device select straps |
| wr_prot | input | 1 | 1 blocks programming |

## Verification
A wrong address counter or page index shows up as wrong bytes in the read-back that follows each write, one byte time after the read command is acknowledged. A wrong decision in the command state or the busy flag shows up at once as a wrong ninth-clock acknowledge on the very next command byte. A STOP that starts a programming cycle it should not have, or fails to start one it should, becomes visible on the next command poll through the acknowledge bit, well within the programming window. A data-line change while SCL is high would be read by the master as a false START or STOP, so it is checked on every cycle.

// File: rtl/eep_slave_pkg.sv
`timescale 1ns/1ps
package eep_slave_pkg;

    localparam logic [3:0] DEV_TYPE  = 4'b1010;
    localparam int         BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CMD_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_COPY,
        SQ_WAIT
    } seq_state_t;

endpackage

// File: rtl/eep_line_sync.sv
`timescale 1ns/1ps
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // metastability stages, idle bus level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl  = scl_pipe[STAGES-1];
    assign sda_lvl  = sda_pipe[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    // data edge while the clock stays high
    assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/eep_mem_array.sv
`timescale 1ns/1ps
module eep_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eep_prog_seq.sv
`timescale 1ns/1ps
module eep_prog_seq
    import eep_slave_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 4000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     prog_req,
    input  logic [ADDR_W-PAGE_W-1:0] prog_page,
    output logic                     busy,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [7:0]               mem_wdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

    seq_state_t                 sq_state;
    seq_state_t                 sq_next;
    logic [7:0]                 pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]      pvalid;
    logic [PAGE_W-1:0]          slot;
    logic [ADDR_W-PAGE_W-1:0]   page_q;
    logic [CNT_W-1:0]           wait_cnt;
    logic                       last_slot;
    logic                       wait_done;

    assign last_slot = (slot == PAGE_W'(PAGE_BYTES - 1));
    assign wait_done = (wait_cnt == CNT_W'(PROG_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_state <= SQ_IDLE;
        else        sq_state <= sq_next;
    end

    always_comb begin
        sq_next = sq_state;
        unique case (sq_state)
            SQ_IDLE: if (prog_req)  sq_next = SQ_COPY;
            SQ_COPY: if (last_slot) sq_next = SQ_WAIT;
            SQ_WAIT: if (wait_done) sq_next = SQ_IDLE;
            default:                sq_next = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pvalid   <= '0;
            slot     <= '0;
            page_q   <= '0;
            wait_cnt <= '0;
        end else begin
            unique case (sq_state)
                SQ_IDLE: begin
                    if (buf_clr) begin
                        pvalid <= '0;
                    end else if (buf_we) begin
                        pvalid[buf_idx] <= 1'b1;
                    end
                    if (prog_req) begin
                        page_q <= prog_page;
                        slot   <= '0;
                    end
                end
                SQ_COPY: begin
                    slot <= slot + PAGE_W'(1);
                    if (last_slot) wait_cnt <= '0;
                end
                SQ_WAIT: begin
                    wait_cnt <= wait_cnt + CNT_W'(1);
                    if (wait_done) pvalid <= '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (sq_state == SQ_IDLE && buf_we) begin
            pbuf[buf_idx] <= buf_data;
        end
    end

    assign busy      = (sq_state != SQ_IDLE);
    assign mem_we    = (sq_state == SQ_COPY) && pvalid[slot];
    assign mem_waddr = {page_q, slot};
    assign mem_wdata = pbuf[slot];

endmodule

// File: rtl/eep_i2c_slave.sv
`timescale 1ns/1ps
module eep_i2c_slave
    import eep_slave_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull,
    input  logic [2:0] chip_sel,
    input  logic       wr_prot
);
    localparam int HI_BITS = ADDR_W - BYTE_BITS;
    localparam int PG_BITS = ADDR_W - PAGE_W;

    slv_state_t          state;
    slv_state_t          state_nx;
    logic                scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0]          bit_cnt;
    logic [7:0]          shreg;
    logic [ADDR_W-1:0]   addr_cnt;
    logic                rd_mode;
    logic                data_seen;
    logic                mack;
    logic                byte_done;
    logic                cmd_hit;
    logic                prog_req;
    logic                prog_busy;
    logic                buf_we;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_waddr;
    logic [7:0]          mem_wdata;
    logic [7:0]          ram_q;
    logic                cmd_ack_phase;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'(BYTE_BITS));
    assign cmd_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel) && !prog_busy;
    assign buf_we    = byte_done && (state == ST_WDATA);
    assign prog_req  = stop_ev && (state == ST_WDATA) && data_seen && !wr_prot;
    assign cmd_ack_phase = (state == ST_CMD_ACK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_CMD;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      ;
                ST_CMD:       if (byte_done) state_nx = cmd_hit ? ST_CMD_ACK : ST_IDLE;
                ST_CMD_ACK:   if (scl_fall)  state_nx = rd_mode ? ST_RDATA : ST_AHI;
                ST_AHI:       if (byte_done) state_nx = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall)  state_nx = ST_ALO;
                ST_ALO:       if (byte_done) state_nx = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall)  state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall)  state_nx = mack ? ST_RDATA : ST_IDLE;
                default:                     state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull  <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            addr_cnt  <= '0;
            rd_mode   <= 1'b0;
            data_seen <= 1'b0;
            mack      <= 1'b0;
        end else if (start_ev) begin
            sda_pull  <= 1'b0;
            bit_cnt   <= '0;
            data_seen <= 1'b0;
        end else if (stop_ev) begin
            sda_pull  <= 1'b0;
            bit_cnt   <= '0;
        end else begin
            unique case (state)
                ST_CMD, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise && bit_cnt < 4'(BYTE_BITS)) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_CMD) begin
                            rd_mode  <= shreg[0];
                            sda_pull <= cmd_hit;
                        end else if (state == ST_AHI) begin
                            addr_cnt[ADDR_W-1:BYTE_BITS] <= shreg[HI_BITS-1:0];
                            sda_pull <= 1'b1;
                        end else if (state == ST_ALO) begin
                            addr_cnt[BYTE_BITS-1:0] <= shreg;
                            sda_pull <= 1'b1;
                        end else begin
                            addr_cnt[PAGE_W-1:0] <= addr_cnt[PAGE_W-1:0] + PAGE_W'(1);
                            data_seen <= 1'b1;
                            sda_pull  <= 1'b1;
                        end
                    end
                end
                ST_CMD_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state == ST_CMD_ACK && rd_mode) begin
                            shreg    <= ram_q;
                            sda_pull <= ~ram_q[7];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        sda_pull <= 1'b0;
                        addr_cnt <= addr_cnt + ADDR_W'(1);
                    end else if (scl_fall) begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_pull <= ~shreg[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                    end else if (scl_fall && mack) begin
                        bit_cnt  <= '0;
                        shreg    <= ram_q;
                        sda_pull <= ~ram_q[7];
                    end
                end
                ST_IDLE: ;
                default: ;
            endcase
        end
    end

    eep_prog_seq #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_clr   (start_ev),
        .buf_we    (buf_we),
        .buf_idx   (addr_cnt[PAGE_W-1:0]),
        .buf_data  (shreg),
        .prog_req  (prog_req),
        .prog_page (addr_cnt[ADDR_W-1:PAGE_W]),
        .busy      (prog_busy),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    eep_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_BITS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_cnt),
        .rdata (ram_q)
    );

    logic unused_pg;
    assign unused_pg = (PG_BITS > 0) ^ scl_lvl ^ scl_lvl;

endmodule

// File: rtl/eep_i2c_slave_chk.sv
`timescale 1ns/1ps
module eep_i2c_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic sda_pull,
    input logic prog_req,
    input logic prog_busy,
    input logic wr_prot,
    input logic cmd_ack_phase
);
    // R2: the drive never changes while the clock stays high
    p_sda_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

    // R8: a request only reaches an idle sequencer
    p_req_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !prog_busy);

    // R8: the sequencer goes busy right after a request
    p_busy_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> prog_busy);

    // R8: no command acknowledge while programming
    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && cmd_ack_phase) |-> !sda_pull);

    // R9: protected writes never request programming
    p_no_req_wp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !wr_prot);

endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_lvl       (scl_lvl),
    .sda_pull      (sda_pull),
    .prog_req      (prog_req),
    .prog_busy     (prog_busy),
    .wr_prot       (wr_prot),
    .cmd_ack_phase (cmd_ack_phase)
);

// File: tb/eep_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module eep_i2c_slave_tb_top;

    localparam logic [2:0] CS     = 3'b101;
    localparam logic [7:0] CMD_W  = 8'hAA;
    localparam logic [7:0] CMD_R  = 8'hAB;
    localparam int         WD_LIM = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       sda_pull;
    logic       sda_bus;
    int         n_cmp = 0;
    int         n_bad = 0;
    logic       done = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    eep_i2c_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_pull (sda_pull),
        .chip_sel (CS),
        .wr_prot  (wp)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(10);
        scl_m = 1'b1; tick(20);
        sda_m = 1'b0; tick(20);
        scl_m = 1'b0; tick(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(10);
        scl_m = 1'b1; tick(20);
        sda_m = 1'b1; tick(20);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;    tick(10);
        scl_m = 1'b1; tick(10);
        seen = sda_bus;
        tick(10);
        scl_m = 1'b0; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic write_seq(input logic [7:0] ahi, input logic [7:0] alo, input int n);
        logic a;
        bus_start();
        send_byte(CMD_W, a); chk("R1", "write cmd ack", a, 1);
        send_byte(ahi, a);   chk("R2", "ahi ack", a, 1);
        send_byte(alo, a);   chk("R2", "alo ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); chk("R2", "data ack", a, 1);
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] ahi, input logic [7:0] alo, input int n);
        logic a;
        bus_start();
        send_byte(CMD_W, a); chk("R1", "cmd ack", a, 1);
        send_byte(ahi, a);   chk("R3", "ahi ack", a, 1);
        send_byte(alo, a);   chk("R3", "alo ack", a, 1);
        bus_start();
        send_byte(CMD_R, a); chk("R6", "read cmd ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        logic a;
        logic ready;
        ready = 1'b0;
        polls = 0;
        for (int i = 0; i < 40 && !ready; i++) begin
            bus_start();
            send_byte(CMD_W, a);
            bus_stop();
            polls++;
            if (a) ready = 1'b1;
        end
        chk("R8", "ready after programming", ready, 1);
    endtask

    task automatic t_reset();
        chk("R11", "sda_pull after reset", sda_pull, 0);
    endtask

    task automatic t_wrong_cs();
        logic a;
        bus_start();
        send_byte(8'hA4, a); chk("R1", "wrong select no ack", a, 0);
        tick(5);
        chk("R1", "released after mismatch", sda_pull, 0);
        bus_start();
        send_byte(8'hBA, a); chk("R1", "wrong type no ack", a, 0);
        bus_stop();
        bus_start();
        send_byte(CMD_R, a); chk("R11", "ack right after reset", a, 1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
    endtask

    task automatic t_byte_write();
        logic a;
        int   p;
        wbuf[0] = 8'hA5;
        write_seq(8'h01, 8'h23, 1);
        bus_start();
        send_byte(CMD_W, a); chk("R8", "write cmd nack while busy", a, 0);
        bus_start();
        send_byte(CMD_R, a); chk("R8", "read cmd nack while busy", a, 0);
        bus_stop();
        wait_ready(p);
        read_seq(8'h01, 8'h23, 1);
        chk("R6", "random read 0x123", rbuf[0], 8'hA5);
    endtask

    task automatic t_ahi_mask();
        read_seq(8'hF9, 8'h23, 1);
        chk("R3", "upper ahi bits ignored", rbuf[0], 8'hA5);
    endtask

    task automatic t_page_wrap();
        int p;
        for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h10 + i);
        write_seq(8'h00, 8'h3C, 6);
        wait_ready(p);
        read_seq(8'h00, 8'h20, 2);
        chk("R4", "wrapped byte at 0x020", rbuf[0], 8'h14);
        chk("R4", "wrapped byte at 0x021", rbuf[1], 8'h15);
        read_seq(8'h00, 8'h3C, 4);
        for (int i = 0; i < 4; i++) chk("R4", "page tail", rbuf[i], 16'(8'h10 + i));
    endtask

    task automatic t_seq_wrap();
        logic a;
        int   p;
        wbuf[0] = 8'h5E;
        write_seq(8'h07, 8'hFF, 1);
        wait_ready(p);
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        write_seq(8'h00, 8'h00, 2);
        wait_ready(p);
        read_seq(8'h07, 8'hFF, 2);
        chk("R5", "top address", rbuf[0], 8'h5E);
        chk("R5", "wrapped to 0", rbuf[1], 8'hC3);
        bus_start();
        send_byte(CMD_R, a); chk("R7", "current read ack", a, 1);
        recv_byte(1'b0, rbuf[0]);
        tick(5);
        chk("R7", "released after nack", sda_pull, 0);
        tick(20);
        chk("R7", "still released", sda_pull, 0);
        bus_stop();
        chk("R7", "current address read", rbuf[0], 8'h3C);
    endtask

    task automatic t_write_protect();
        logic a;
        wp = 1'b1;
        wbuf[0] = 8'h00;
        write_seq(8'h01, 8'h23, 1);
        bus_start();
        send_byte(CMD_W, a); chk("R9", "no programming under protect", a, 1);
        bus_stop();
        wp = 1'b0;
        read_seq(8'h01, 8'h23, 1);
        chk("R9", "array unchanged", rbuf[0], 8'hA5);
    endtask

    task automatic t_no_data();
        logic a;
        write_seq(8'h01, 8'h23, 0);
        bus_start();
        send_byte(CMD_W, a); chk("R10", "no programming without data", a, 1);
        bus_stop();
        read_seq(8'h01, 8'h23, 1);
        chk("R10", "array unchanged", rbuf[0], 8'hA5);
    endtask

    task automatic t_restart_cancel();
        logic a;
        bus_start();
        send_byte(CMD_W, a);
        send_byte(8'h00, a);
        send_byte(8'h20, a);
        send_byte(8'h99, a); chk("R6", "data ack before restart", a, 1);
        bus_start();
        send_byte(CMD_R, a); chk("R6", "read after restart acked", a, 1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        chk("R6", "read from advanced address", rbuf[0], 8'h15);
        bus_start();
        send_byte(CMD_W, a); chk("R6", "cancelled write left idle", a, 1);
        bus_stop();
        read_seq(8'h00, 8'h20, 1);
        chk("R6", "cancelled data not stored", rbuf[0], 8'h14);
    endtask

    task automatic t_mid_byte_start();
        logic a;
        logic s;
        bus_start();
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        bus_start();
        send_byte(CMD_R, a); chk("R12", "command after abandoned byte", a, 1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
    endtask

    initial begin : main
        tick(10);
        rst_n = 1'b1;
        tick(10);
        t_reset();
        t_wrong_cs();
        t_byte_write();
        t_ahi_mask();
        t_page_wrap();
        t_seq_wrap();
        t_write_protect();
        t_no_data();
        t_restart_cancel();
        t_mid_byte_start();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (WD_LIM) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule